// File: doc/BRIEF.md
# Factorial Accelerator Register Front End

This block is a memory-mapped peripheral that computes 32-bit factorials in hardware. Software writes an operand to the operand/result register. A multi-cycle engine then multiplies and decrements once per clock until it has the product. While it works, a busy flag in the status word stays high. When it finishes, the result overwrites the operand in the same register. If software has set the completion-interrupt enable, finishing also raises a cause bit in a shared interrupt cause register.

The cause register drives one level-sensitive interrupt line. Software reads it directly, sets bits through one write-only address and clears bits through another. A neighbouring transfer engine can raise its own cause bit through a dedicated input pulse. The register window also holds a constant identification word and a scratch register that stores the inverse of whatever is written to it.

Bus accesses are single-cycle strobes carrying an address, a size in bytes, and write data. Read data is registered and appears one clock after the read strobe.

Top module: `fact_accel`

## Requirements
- R1: A 4-byte read of offset 0x00 returns 0x010000ED on `rd_data` in the cycle after the read strobe.
- R2: A 4-byte write to offset 0x04 stores the bitwise inverse of the write data, and a read of 0x04 returns the stored value.
- R3: A 4-byte write to offset 0x08 while idle loads the operand and sets busy (status bit 0). A write to 0x08 while busy changes neither the operand nor the computation.
- R4: The computation ends with n·(n−1)·…·1 modulo 2^32 readable at 0x08 and busy cleared, where an operand of 0 or 1 gives 1. While busy, 0x08 reads the operand.
- R5: Status offset 0x20 bit 7 is a read/write completion-interrupt enable. Completion with the enable set sets cause bit 0. Completion with the enable clear leaves the causes unchanged.
- R6: Offset 0x24 reads the 32-bit cause register. A write to 0x60 ORs the data into it, and a write to 0x64 clears the bits set in the data. A hardware cause raised in the same cycle as a clear write wins.
- R7: `irq` is high exactly when the cause register is nonzero. A pulse on `dma_evt` sets cause bit 8.
- R8: A write whose size is not 4 changes no register, and a read whose size is not 4 returns 0xFFFFFFFF.
- R9: A read of any offset other than 0x00, 0x04, 0x08, 0x20 or 0x24 returns 0xFFFFFFFF.
- R10: After synchronous reset, busy, the operand, the scratch register, the enable and the causes are zero, and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_size | input | 4 | Access size in bytes |
| bus_wdata | input | 32 | Write data |
| rd_data | output | 32 | Registered read data, valid the cycle after `bus_rd` |
| dma_evt | input | 1 | One-cycle pulse that sets cause bit 8 |
| irq | output | 1 | Level interrupt, high while any cause bit is set |

## Verification
The bench loads a second operand right after the first, while the engine is busy. A design that failed to gate the load would return the wrong factorial. It uses operands 0, 1, 13 and 20, where 0 and 1 must both give 1 and 13 onward wraps past 32 bits. An engine that stops one step early or late, or that does not truncate, shows up as a wrong product. It pulses `dma_evt` in the same cycle as a clear of bit 8. A design with the wrong set/clear priority would leave the line low. It issues narrow writes and reads, and a design that decodes only the address would corrupt the scratch register, the enable or the causes, or return real data.

// File: rtl/fact_accel_pkg.sv
package fact_accel_pkg;
  localparam int DATA_W = 32;
  localparam logic [DATA_W-1:0] ID_WORD = 32'h010000ED;
  localparam int OFF_ID      = 'h00;
  localparam int OFF_SCRATCH = 'h04;
  localparam int OFF_FACT    = 'h08;
  localparam int OFF_STATUS  = 'h20;
  localparam int OFF_CAUSE   = 'h24;
  localparam int OFF_SET     = 'h60;
  localparam int OFF_CLR     = 'h64;
  localparam int BUSY_BIT    = 0;
  localparam int IEN_BIT     = 7;
  localparam int FACT_CAUSE  = 0;
  localparam int DMA_CAUSE   = 8;
  localparam logic [3:0] FULL_SIZE = 4'd4;
endpackage

// File: rtl/fact_engine.sv
module fact_engine #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         busy,
  output logic [W-1:0] value,
  output logic         done
);
  logic [W-1:0] acc, cnt;
  logic last_step;

  assign last_step = busy && (cnt <= W'(1));
  assign done = last_step;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      value <= '0;
      acc   <= '0;
      cnt   <= '0;
    end else if (!busy) begin
      if (load) begin
        value <= load_val;
        cnt   <= load_val;
        acc   <= W'(1);
        busy  <= 1'b1;
      end
    end else if (last_step) begin
      value <= acc;
      busy  <= 1'b0;
    end else begin
      acc <= acc * cnt;
      cnt <= cnt - W'(1);
    end
  end

  // R3: busy only rises in response to a load request
  assert_busy_needs_load_R3: assert property (@(posedge clk) disable iff (rst)
    !busy |=> (!busy || $past(load)));
  // R3: a load while mid-computation leaves the operand alone
  assert_load_ignored_R3: assert property (@(posedge clk) disable iff (rst)
    (busy && load && !last_step) |=> $stable(value));
endmodule

// File: rtl/irq_cause.sv
module irq_cause #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_vec,
  input  logic [W-1:0] clr_vec,
  output logic [W-1:0] cause
);
  always_ff @(posedge clk) begin
    if (rst) cause <= '0;
    else     cause <= (cause & ~clr_vec) | set_vec;
  end

  // R6: every requested set bit is present next cycle, even under a clear
  assert_set_wins_R6: assert property (@(posedge clk) disable iff (rst)
    (set_vec != '0) |=> ((cause & $past(set_vec)) == $past(set_vec)));
  // R6: cleared bits without a concurrent set are gone next cycle
  assert_clear_takes_R6: assert property (@(posedge clk) disable iff (rst)
    (clr_vec != '0) |=> ((cause & $past(clr_vec & ~set_vec)) == '0));
endmodule

// File: rtl/fact_accel.sv
module fact_accel
  import fact_accel_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [3:0]        bus_size,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] rd_data,
  input  logic              dma_evt,
  output logic              irq
);
  localparam logic [DATA_W-1:0] ALL_ONES = '1;

  logic full_wr, full_rd;
  logic [DATA_W-1:0] scratch_q;
  logic ien_q;
  logic eng_busy, eng_done;
  logic [DATA_W-1:0] eng_value, cause, set_vec, clr_vec;

  function automatic logic at(input logic [ADDR_W-1:0] a, input int off);
    return a == ADDR_W'(off);
  endfunction

  assign full_wr = bus_wr && (bus_size == FULL_SIZE);
  assign full_rd = bus_rd && (bus_size == FULL_SIZE);

  fact_engine #(.W(DATA_W)) u_engine (
    .clk      (clk),
    .rst      (rst),
    .load     (full_wr && at(bus_addr, OFF_FACT)),
    .load_val (bus_wdata),
    .busy     (eng_busy),
    .value    (eng_value),
    .done     (eng_done)
  );

  always_comb begin
    set_vec = (full_wr && at(bus_addr, OFF_SET)) ? bus_wdata : '0;
    if (eng_done && ien_q) set_vec[FACT_CAUSE] = 1'b1;
    if (dma_evt)           set_vec[DMA_CAUSE]  = 1'b1;
    clr_vec = (full_wr && at(bus_addr, OFF_CLR)) ? bus_wdata : '0;
  end

  irq_cause #(.W(DATA_W)) u_cause (
    .clk     (clk),
    .rst     (rst),
    .set_vec (set_vec),
    .clr_vec (clr_vec),
    .cause   (cause)
  );

  assign irq = |cause;

  always_ff @(posedge clk) begin
    if (rst) begin
      scratch_q <= '0;
      ien_q     <= 1'b0;
    end else if (full_wr) begin
      if (at(bus_addr, OFF_SCRATCH)) scratch_q <= ~bus_wdata;
      if (at(bus_addr, OFF_STATUS))  ien_q     <= bus_wdata[IEN_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= ALL_ONES;
    end else if (bus_rd) begin
      rd_data <= ALL_ONES;
      if (full_rd) begin
        if (at(bus_addr, OFF_ID))      rd_data <= ID_WORD;
        if (at(bus_addr, OFF_SCRATCH)) rd_data <= scratch_q;
        if (at(bus_addr, OFF_FACT))    rd_data <= eng_value;
        if (at(bus_addr, OFF_STATUS)) begin
          rd_data           <= '0;
          rd_data[BUSY_BIT] <= eng_busy;
          rd_data[IEN_BIT]  <= ien_q;
        end
        if (at(bus_addr, OFF_CAUSE))   rd_data <= cause;
      end
    end
  end

  // R5: completion with the enable set raises the factorial cause
  assert_done_cause_R5: assert property (@(posedge clk) disable iff (rst)
    (eng_done && ien_q) |=> cause[FACT_CAUSE]);
  // R7: a transfer event drives the line high next cycle
  assert_dma_irq_R7: assert property (@(posedge clk) disable iff (rst)
    dma_evt |=> irq);
  // R8: narrow writes leave the scratch register and the enable untouched
  assert_narrow_write_R8: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_size != FULL_SIZE) |=> ($stable(scratch_q) && $stable(ien_q)));
endmodule

// File: tb/fact_accel_bench.sv
module fact_accel_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 20;

  logic clk = 1'b0, rst = 1'b1;
  logic [AW-1:0] bus_addr = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0, dma_evt = 1'b0;
  logic [3:0] bus_size = 4'd4;
  logic [31:0] bus_wdata = '0, rd_data;
  logic irq;
  int n_chk = 0, n_bad = 0;
  logic finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fact_accel #(.ADDR_W(AW)) u_fact_accel (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_size(bus_size), .bus_wdata(bus_wdata), .rd_data(rd_data),
    .dma_evt(dma_evt), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d, input logic [3:0] sz = 4'd4);
    @(negedge clk);
    bus_addr = AW'(a); bus_wdata = d; bus_size = sz; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_size = 4'd4;
  endtask

  task automatic rd(input int a, output logic [31:0] d, input logic [3:0] sz = 4'd4);
    @(negedge clk);
    bus_addr = AW'(a); bus_size = sz; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0; bus_size = 4'd4;
    d = rd_data;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 300; i++) begin
      rd('h20, s);
      if (!s[0]) return;
    end
    chk("R4 busy never cleared", 32'd1, 32'd0);
  endtask

  function automatic logic [31:0] fact_ref(input logic [31:0] n);
    logic [31:0] r = 32'd1;
    for (int k = 2; k <= int'(n); k++) r = r * 32'(k);
    return r;
  endfunction

  task automatic t_reset();
    logic [31:0] d;
    rd('h20, d); chk("R10 status", d, 32'h0);
    rd('h08, d); chk("R10 operand", d, 32'h0);
    rd('h04, d); chk("R10 scratch", d, 32'h0);
    rd('h24, d); chk("R10 cause", d, 32'h0);
    chk("R10 irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_ident();
    logic [31:0] d;
    rd('h00, d); chk("R1 id", d, 32'h010000ED);
  endtask

  task automatic t_scratch();
    logic [31:0] d;
    wr('h04, 32'h12345678); rd('h04, d); chk("R2 scratch inv", d, 32'hEDCBA987);
    wr('h04, 32'h0);        rd('h04, d); chk("R2 scratch ones", d, 32'hFFFFFFFF);
  endtask

  task automatic t_fact(input logic [31:0] n);
    logic [31:0] d;
    wr('h08, n);
    wait_idle();
    rd('h08, d); chk("R4 factorial", d, fact_ref(n));
  endtask

  task automatic t_busy_ignore();
    logic [31:0] d;
    wr('h08, 32'd10);
    wr('h08, 32'd3);
    rd('h20, d); chk("R3 busy set", d & 32'h1, 32'h1);
    rd('h08, d); chk("R4 operand while busy", d, 32'd10);
    wait_idle();
    rd('h08, d); chk("R3 second load ignored", d, 32'd3628800);
  endtask

  task automatic t_enable();
    logic [31:0] d;
    wr('h20, 32'h80); rd('h20, d); chk("R5 enable readback", d, 32'h80);
    t_fact(32'd4);
    rd('h24, d); chk("R5 cause on done", d, 32'h1);
    chk("R7 irq high", {31'b0, irq}, 32'h1);
    wr('h64, 32'h1); rd('h24, d); chk("R6 clear", d, 32'h0);
    chk("R7 irq low", {31'b0, irq}, 32'h0);
    wr('h20, 32'h0);
    t_fact(32'd5);
    rd('h24, d); chk("R5 no cause when disabled", d, 32'h0);
  endtask

  task automatic t_cause();
    logic [31:0] d;
    wr('h60, 32'hA0000010); wr('h60, 32'h00000101);
    rd('h24, d); chk("R6 set OR", d, 32'hA0000111);
    wr('h64, 32'h80000011); rd('h24, d); chk("R6 clear mask", d, 32'h20000100);
    wr('h64, 32'hFFFFFFFF); rd('h24, d); chk("R6 clear all", d, 32'h0);
    @(negedge clk);
    dma_evt = 1'b1;
    @(negedge clk);
    dma_evt = 1'b0;
    rd('h24, d); chk("R7 dma cause", d, 32'h100);
    chk("R7 dma irq", {31'b0, irq}, 32'h1);
    wr('h64, 32'h100);
    @(negedge clk);
    bus_addr = AW'('h64); bus_wdata = 32'h100; bus_size = 4'd4; bus_wr = 1'b1; dma_evt = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; dma_evt = 1'b0;
    rd('h24, d); chk("R6 set beats clear", d, 32'h100);
    wr('h64, 32'h100);
  endtask

  task automatic t_size();
    logic [31:0] d;
    wr('h04, 32'h0000FFFF);
    wr('h04, 32'h0, 4'd2);  rd('h04, d); chk("R8 narrow scratch write", d, 32'hFFFF0000);
    rd('h04, d, 4'd2);      chk("R8 narrow read", d, 32'hFFFFFFFF);
    rd('h00, d, 4'd8);      chk("R8 wide read id", d, 32'hFFFFFFFF);
    wr('h20, 32'h80, 4'd1); rd('h20, d); chk("R8 narrow enable write", d, 32'h0);
    wr('h60, 32'h4, 4'd2);  rd('h24, d); chk("R8 narrow set write", d, 32'h0);
    wr('h08, 32'd6, 4'd8);  rd('h20, d); chk("R8 narrow operand write", d, 32'h0);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    rd('h10, d); chk("R9 hole", d, 32'hFFFFFFFF);
    rd('h60, d); chk("R9 set view", d, 32'hFFFFFFFF);
    rd('h80, d); chk("R9 high", d, 32'hFFFFFFFF);
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got 0x%08h expected 0x%08h", 32'd0, 32'd1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_ident();
    t_scratch();
    t_fact(32'd0);
    t_fact(32'd1);
    t_fact(32'd5);
    t_fact(32'd13);
    t_fact(32'd20);
    t_busy_ignore();
    t_enable();
    t_cause();
    t_size();
    t_unmapped();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule